// File: doc/BRIEF.md
# Vector Iteration Exception Capture Unit

This block steps through the elements of a short-vector floating-point operation one element per clock and issues each element index to an external arithmetic datapath. The datapath answers in the same cycle with an exceptional flag and a set of cumulative status flags for that element. The block allows writeback for elements that complete cleanly. It stops at the first element that raises an exceptional condition, and no writeback happens for that element or for any element after it. Support code can therefore re-run the faulting element and the rest of the vector on untouched source registers.

On a fault the block fills an exception control word and raises a one-cycle trap. The word holds a valid-vector bit, a synchronous-exception bit (present only when `VERSION` is 2), a trap-pending bit and an iteration field. The iteration field tells support code how many elements remain after the faulting one. A scalar operation runs as a one-element vector. Whether a scalar trap sets the valid-vector bit is a parameter. Whether the faulting element's cumulative flags are merged is also a parameter. Software clears or rewrites the control word through a write port. A new start is refused while a trap is pending.

Top module: `vecit_trap_unit`

## Requirements
- R1: After synchronous reset, `ecr_o`, `cum_flags_o`, `trap_o`, `done_o` and `iter_valid_o` are all zero.
- R2: A start pulse accepted while idle runs N elements, where N is `len_m1_i`+1, or 1 when `scalar_i` is 1. `iter_valid_o` is high with `iter_idx_o` = 0,1,…,N-1 on consecutive cycles, beginning the cycle after the start. If no element faults, `done_o` pulses for one cycle in the cycle after the last element.
- R3: `wb_en_o` is high for every issued element whose `exc_i` is low. It is low for the faulting element, and no element is issued after a fault.
- R4: When element k of an N-element vector faults, `trap_o` pulses in the next cycle. In that same cycle `ecr_o[3]` (valid-vector) is 1, `ecr_o[5]` (trap pending) is 1, and `ecr_o[2:0]` = (N-2-k) mod 8, so 3'b111 means no elements remain.
- R5: A scalar trap writes `ecr_o[2:0]` = 3'b111, and writes `ecr_o[3]` = `SCALAR_VV`.
- R6: `cum_flags_o` accumulates by OR the `cflags_i` of every committed element. The faulting element's flags are merged only when `CUM_ON_FAULT` is 1.
- R7: With `VERSION`=2 a trap sets `ecr_o[4]` (synchronous exception) to 1. With `VERSION`=1, `ecr_o[4]` reads 0 at all times and ignores writes.
- R8: While `ecr_o[5]` is 1, a start pulse is refused and no element is issued.
- R9: When `ecr_we_i` is 1, the control word loads `ecr_wd_i` in the next cycle. This includes bit 5 (so writing 0 clears a pending trap) and bit 4 only when `VERSION`=2.
- R10: `trap_o` is never high on two consecutive cycles, and never in the same cycle as `done_o`.
- R11: A start pulse while a vector is running is ignored; the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a vector operation |
| scalar_i | input | 1 | Operation is scalar (one element) |
| len_m1_i | input | LEN_W | Vector length minus one, latched at start |
| iter_valid_o | output | 1 | An element is issued this cycle |
| iter_idx_o | output | LEN_W | Index of the issued element |
| exc_i | input | 1 | Issued element raised an exceptional condition |
| cflags_i | input | NFLAG | Cumulative status flags of the issued element |
| wb_en_o | output | 1 | Writeback allowed for the issued element |
| done_o | output | 1 | Vector finished with no fault (pulse) |
| trap_o | output | 1 | Trap to support code (pulse) |
| ecr_o | output | LEN_W+3 | Control word {pend, sync, vv, iter} |
| ecr_we_i | input | 1 | Write enable for the control word |
| ecr_wd_i | input | LEN_W+3 | Write data for the control word |
| cum_flags_o | output | NFLAG | Accumulated cumulative flags |

## Verification
The assertions assume that `exc_i` and `cflags_i` are meaningful only while `iter_valid_o` is high. They also assume that the datapath answers in the same cycle as the issue. The stimulus derives `exc_i` combinationally from the issued index and a chosen fault position, so a fault can never arrive outside an issued element. Control-word writes are made only while the block is idle, which keeps a software write from racing a trap capture in the same cycle.

// File: rtl/vit_pkg.sv
package vit_pkg;
   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_st_e;

   // control word bit positions above the iteration field
   localparam int VV_OFS   = 0;
   localparam int SYNC_OFS = 1;
   localparam int PEND_OFS = 2;
   localparam int CTRL_BITS = 3;
endpackage

// File: rtl/vit_seq.sv
module vit_seq #(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             scalar_i,
   input  logic [LEN_W-1:0] len_m1_i,
   input  logic             hold_i,
   input  logic             exc_i,
   output logic             iter_valid_o,
   output logic [LEN_W-1:0] idx_o,
   output logic [LEN_W-1:0] last_o,
   output logic             scalar_o,
   output logic             fault_o,
   output logic             commit_o,
   output logic             done_o
);
   import vit_pkg::*;

   seq_st_e          st_q;
   logic [LEN_W-1:0] idx_q;
   logic [LEN_W-1:0] last_q;
   logic             scal_q;
   logic             done_q;
   logic             at_last;

   assign at_last = (idx_q == last_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= SEQ_IDLE;
         idx_q  <= '0;
         last_q <= '0;
         scal_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (start_i && !hold_i) begin
                  st_q   <= SEQ_RUN;
                  idx_q  <= '0;
                  last_q <= scalar_i ? '0 : len_m1_i;
                  scal_q <= scalar_i;
               end
            end
            SEQ_RUN: begin
               if (exc_i) begin
                  st_q <= SEQ_IDLE;
               end else if (at_last) begin
                  st_q   <= SEQ_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign iter_valid_o = (st_q == SEQ_RUN);
   assign idx_o        = idx_q;
   assign last_o       = last_q;
   assign scalar_o     = scal_q;
   assign fault_o      = iter_valid_o && exc_i;
   assign commit_o     = iter_valid_o && !exc_i;
   assign done_o       = done_q;
endmodule

// File: rtl/vit_capture.sv
module vit_capture #(
   parameter int LEN_W     = 3,
   parameter int VERSION   = 2,
   parameter bit SCALAR_VV = 1'b1,
   localparam int EW       = LEN_W + vit_pkg::CTRL_BITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fault_i,
   input  logic [LEN_W-1:0] idx_i,
   input  logic [LEN_W-1:0] last_i,
   input  logic             scalar_i,
   input  logic             we_i,
   input  logic [EW-1:0]    wd_i,
   output logic [EW-1:0]    ecr_o,
   output logic             pend_o,
   output logic             trap_o
);
   import vit_pkg::*;

   logic [LEN_W-1:0] itr_q;
   logic             vv_q;
   logic             pend_q;
   logic             trap_q;
   logic             sync_bit;
   logic [LEN_W-1:0] remain_code;

   // elements left after the faulting one, minus one, modulo 2**LEN_W
   assign remain_code = last_i - idx_i - 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         itr_q  <= '0;
         vv_q   <= 1'b0;
         pend_q <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         trap_q <= fault_i;
         if (fault_i) begin
            itr_q  <= remain_code;
            vv_q   <= scalar_i ? SCALAR_VV : 1'b1;
            pend_q <= 1'b1;
         end else if (we_i) begin
            itr_q  <= wd_i[LEN_W-1:0];
            vv_q   <= wd_i[LEN_W+VV_OFS];
            pend_q <= wd_i[LEN_W+PEND_OFS];
         end
      end
   end

   generate
      if (VERSION == 2) begin : g_sync_reg
         logic sync_q;
         always_ff @(posedge clk) begin
            if (rst)          sync_q <= 1'b0;
            else if (fault_i) sync_q <= 1'b1;
            else if (we_i)    sync_q <= wd_i[LEN_W+SYNC_OFS];
         end
         assign sync_bit = sync_q;
      end else begin : g_sync_raz
         assign sync_bit = 1'b0;
      end
   endgenerate

   assign ecr_o  = {pend_q, sync_bit, vv_q, itr_q};
   assign pend_o = pend_q;
   assign trap_o = trap_q;
endmodule

// File: rtl/vit_cumflags.sv
module vit_cumflags #(
   parameter int NFLAG        = 5,
   parameter bit CUM_ON_FAULT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit_i,
   input  logic             fault_i,
   input  logic [NFLAG-1:0] flags_i,
   output logic [NFLAG-1:0] cum_o
);
   logic [NFLAG-1:0] cum_q;
   logic             merge;

   generate
      if (CUM_ON_FAULT) begin : g_merge_fault
         assign merge = commit_i || fault_i;
      end else begin : g_drop_fault
         assign merge = commit_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        cum_q <= '0;
      else if (merge) cum_q <= cum_q | flags_i;
   end

   assign cum_o = cum_q;
endmodule

// File: rtl/vecit_trap_unit.sv
module vecit_trap_unit #(
   parameter int LEN_W        = 3,
   parameter int NFLAG        = 5,
   parameter int VERSION      = 2,
   parameter bit SCALAR_VV    = 1'b1,
   parameter bit CUM_ON_FAULT = 1'b0,
   localparam int EW          = LEN_W + vit_pkg::CTRL_BITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             scalar_i,
   input  logic [LEN_W-1:0] len_m1_i,
   output logic             iter_valid_o,
   output logic [LEN_W-1:0] iter_idx_o,
   input  logic             exc_i,
   input  logic [NFLAG-1:0] cflags_i,
   output logic             wb_en_o,
   output logic             done_o,
   output logic             trap_o,
   output logic [EW-1:0]    ecr_o,
   input  logic             ecr_we_i,
   input  logic [EW-1:0]    ecr_wd_i,
   output logic [NFLAG-1:0] cum_flags_o
);
   generate
      if (VERSION != 1 && VERSION != 2) begin : g_bad_version
         $error("vecit_trap_unit: VERSION must be 1 or 2");
      end
      if (LEN_W < 1 || LEN_W > 6) begin : g_bad_len
         $error("vecit_trap_unit: LEN_W out of range");
      end
      if (NFLAG < 1) begin : g_bad_nflag
         $error("vecit_trap_unit: NFLAG must be positive");
      end
   endgenerate

   logic [LEN_W-1:0] last_w;
   logic             scal_w;
   logic             fault_w;
   logic             commit_w;
   logic             pend_w;

   vit_seq #(.LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .scalar_i     (scalar_i),
      .len_m1_i     (len_m1_i),
      .hold_i       (pend_w),
      .exc_i        (exc_i),
      .iter_valid_o (iter_valid_o),
      .idx_o        (iter_idx_o),
      .last_o       (last_w),
      .scalar_o     (scal_w),
      .fault_o      (fault_w),
      .commit_o     (commit_w),
      .done_o       (done_o)
   );

   vit_capture #(.LEN_W(LEN_W), .VERSION(VERSION), .SCALAR_VV(SCALAR_VV)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .fault_i  (fault_w),
      .idx_i    (iter_idx_o),
      .last_i   (last_w),
      .scalar_i (scal_w),
      .we_i     (ecr_we_i),
      .wd_i     (ecr_wd_i),
      .ecr_o    (ecr_o),
      .pend_o   (pend_w),
      .trap_o   (trap_o)
   );

   vit_cumflags #(.NFLAG(NFLAG), .CUM_ON_FAULT(CUM_ON_FAULT)) u_cum (
      .clk      (clk),
      .rst      (rst),
      .commit_i (commit_w),
      .fault_i  (fault_w),
      .flags_i  (cflags_i),
      .cum_o    (cum_flags_o)
   );

   assign wb_en_o = commit_w;
endmodule

// File: rtl/vit_chk.sv
module vit_chk #(
   parameter int LEN_W   = 3,
   parameter int VERSION = 2,
   parameter int EW      = LEN_W + 3
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             iter_valid_o,
   input logic [LEN_W-1:0] iter_idx_o,
   input logic             exc_i,
   input logic             wb_en_o,
   input logic             done_o,
   input logic             trap_o,
   input logic [EW-1:0]    ecr_o
);
   AST_NO_ISSUE_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
      (iter_valid_o && exc_i) |=> !iter_valid_o); // R3
   AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst)
      (iter_valid_o && exc_i) |-> !wb_en_o); // R3
   AST_FAULT_TRAPS: assert property (@(posedge clk) disable iff (rst)
      (iter_valid_o && exc_i) |=> (trap_o && ecr_o[EW-1])); // R4
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
      (iter_valid_o && !exc_i) |=> (!iter_valid_o || iter_idx_o == LEN_W'($past(iter_idx_o) + 1'b1))); // R2
   AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
      trap_o |=> !trap_o); // R10
   AST_TRAP_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
      !(trap_o && done_o)); // R10
   AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (ecr_o[EW-1] && !iter_valid_o) |=> !iter_valid_o); // R8
   AST_SYNC_RAZ: assert property (@(posedge clk) disable iff (rst)
      (VERSION == 1) |-> !ecr_o[EW-2]); // R7
endmodule

bind vecit_trap_unit vit_chk #(.LEN_W(LEN_W), .VERSION(VERSION), .EW(EW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .start_i      (start_i),
   .iter_valid_o (iter_valid_o),
   .iter_idx_o   (iter_idx_o),
   .exc_i        (exc_i),
   .wb_en_o      (wb_en_o),
   .done_o       (done_o),
   .trap_o       (trap_o),
   .ecr_o        (ecr_o)
);

// File: tb/vecit_trap_unit_tb_top.sv
module vecit_trap_unit_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic       start_i = 0, scalar_i = 0, ecr_we_i = 0;
   logic [2:0] len_m1_i = 0;
   logic [5:0] ecr_wd_i = 0;
   logic       exc_a, exc_b;
   logic [4:0] cfl_a, cfl_b;
   int         fault_k = 99;

   logic       iv_a, wb_a, done_a, trap_a, iv_b, wb_b, done_b, trap_b;
   logic [2:0] idx_a, idx_b;
   logic [5:0] ecr_a, ecr_b;
   logic [4:0] cum_a, cum_b;

   function automatic logic [4:0] flag_of(int i);
      return 5'(5'b1 << (i % 5));
   endfunction

   always_comb exc_a = iv_a && (int'(idx_a) == fault_k);
   always_comb exc_b = iv_b && (int'(idx_b) == fault_k);
   always_comb cfl_a = flag_of(int'(idx_a));
   always_comb cfl_b = flag_of(int'(idx_b));

   vecit_trap_unit dut_i (
      .clk(clk), .rst(rst), .start_i(start_i), .scalar_i(scalar_i), .len_m1_i(len_m1_i),
      .iter_valid_o(iv_a), .iter_idx_o(idx_a), .exc_i(exc_a), .cflags_i(cfl_a),
      .wb_en_o(wb_a), .done_o(done_a), .trap_o(trap_a), .ecr_o(ecr_a),
      .ecr_we_i(ecr_we_i), .ecr_wd_i(ecr_wd_i), .cum_flags_o(cum_a));

   vecit_trap_unit #(.VERSION(1), .SCALAR_VV(1'b0), .CUM_ON_FAULT(1'b1)) dut_v1_i (
      .clk(clk), .rst(rst), .start_i(start_i), .scalar_i(scalar_i), .len_m1_i(len_m1_i),
      .iter_valid_o(iv_b), .iter_idx_o(idx_b), .exc_i(exc_b), .cflags_i(cfl_b),
      .wb_en_o(wb_b), .done_o(done_b), .trap_o(trap_b), .ecr_o(ecr_b),
      .ecr_we_i(ecr_we_i), .ecr_wd_i(ecr_wd_i), .cum_flags_o(cum_b));

   int n_chk = 0, n_bad = 0;
   int exp_q[$];
   logic [4:0] m_cum_a = 0, m_cum_b = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the expected index of every issued element (R2, R3)
   always @(negedge clk) begin
      if (!rst && iv_a) begin
         if (exp_q.size() == 0) check(0, "R2", "unexpected issue", int'(idx_a), -1);
         else begin
            int e;
            e = exp_q.pop_front();
            check(int'(idx_a) == e, "R2", "issued index", int'(idx_a), e);
            check(wb_a == (e != fault_k), "R3", "writeback gate", int'(wb_a), int'(e != fault_k));
            check(iv_b && idx_b == idx_a, "R2", "v1 instance in step", int'(idx_b), int'(idx_a));
         end
      end
   end

   task automatic run(int len, bit scal, int fk, int poke);
      int n;
      bit seen;
      n = scal ? 1 : len;
      fault_k = fk;
      for (int i = 0; i < n && i <= fk; i++) exp_q.push_back(i);
      @(posedge clk); #1;
      start_i = 1; scalar_i = scal; len_m1_i = 3'(len - 1);
      @(posedge clk); #1;
      start_i = 0;
      if (poke > 0) begin
         repeat (poke) @(posedge clk);
         #1 start_i = 1; len_m1_i = 3'd1;
         @(posedge clk); #1 start_i = 0;
      end
      seen = 0;
      for (int c = 0; c < 20 && !seen; c++) begin
         @(negedge clk);
         if (trap_a || done_a) seen = 1;
      end
      check(seen, "R2", "run ended", int'(seen), 1);
      if (fk < n) begin
         for (int i = 0; i < fk; i++) begin m_cum_a |= flag_of(i); m_cum_b |= flag_of(i); end
         m_cum_b |= flag_of(fk);
         check(trap_a && !done_a, "R4", "trap pulse", int'(trap_a), 1);
         check(ecr_a[2:0] == 3'(n - 2 - fk), "R4", "iteration field", int'(ecr_a[2:0]), (n - 2 - fk) & 7);
         check(ecr_a[5] && ecr_a[3], "R4", "pend/vv", int'(ecr_a[5:3]), 5);
         check(ecr_a[4], "R7", "v2 sync bit", int'(ecr_a[4]), 1);
         check(!ecr_b[4], "R7", "v1 sync bit", int'(ecr_b[4]), 0);
         if (scal) begin
            check(ecr_a[3:0] == 4'hF, "R5", "scalar vv=1 field", int'(ecr_a[3:0]), 15);
            check(ecr_b[3:0] == 4'h7, "R5", "scalar vv=0 field", int'(ecr_b[3:0]), 7);
         end
         @(negedge clk);
         check(!trap_a, "R10", "trap one cycle", int'(trap_a), 0);
      end else begin
         for (int i = 0; i < n; i++) begin m_cum_a |= flag_of(i); m_cum_b |= flag_of(i); end
         check(done_a && !trap_a, "R2", "done pulse", int'(done_a), 1);
         @(negedge clk);
         check(!done_a, "R2", "done one cycle", int'(done_a), 0);
      end
      check(cum_a == m_cum_a, "R6", "cum flags no-merge", int'(cum_a), int'(m_cum_a));
      check(cum_b == m_cum_b, "R6", "cum flags merge", int'(cum_b), int'(m_cum_b));
      check(exp_q.size() == 0, "R3", "all expected issued", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic wr(logic [5:0] d);
      @(posedge clk); #1 ecr_we_i = 1; ecr_wd_i = d;
      @(posedge clk); #1 ecr_we_i = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      check(ecr_a == 0 && cum_a == 0 && !trap_a && !done_a && !iv_a, "R1", "reset state",
            int'({ecr_a, cum_a}), 0);
      run(8, 0, 99, 0);            // clean vector
      run(4, 0, 99, 2);            // R11: start while busy is ignored
      run(8, 0, 2, 0);             // fault mid-vector, 5 remain -> 4
      // R8: start refused while trap pending
      fault_k = 99;
      @(posedge clk); #1 start_i = 1; len_m1_i = 3'd3;
      @(posedge clk); #1 start_i = 0;
      repeat (3) @(negedge clk);
      check(!iv_a, "R8", "start refused while pending", int'(iv_a), 0);
      wr(6'h00);
      check(ecr_a == 0, "R9", "write clears control word", int'(ecr_a), 0);
      run(8, 0, 7, 0);             // fault on last element -> 3'b111
      wr(6'h00);
      run(1, 0, 0, 0);             // one-element vector fault
      wr(6'h00);
      run(5, 1, 0, 0);             // scalar fault
      wr(6'h1D);                   // sync=1, vv=1, iter=5, pend=0
      check(ecr_a == 6'h1D, "R9", "v2 write", int'(ecr_a), 'h1D);
      check(ecr_b == 6'h0D, "R7", "v1 sync ignores write", int'(ecr_b), 'h0D);
      wr(6'h00);
      run(3, 0, 0, 0);             // fault on first element, 2 remain -> 1
      wr(6'h00);
      run(2, 1, 99, 0);            // clean scalar
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(5 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule